// File: doc/BRIEF.md
# Second-Level Cache Miss and Prefetch Tracker

This block decides whether each processor request to a direct-mapped, sub-blocked external cache can be taken this cycle. It combines the request (address, read or write, burst flag) with the tag lookup result for that address. It keeps track of what is still in flight toward memory: one read miss, one write miss, a small set of ownership upgrades for writes that hit shared data, and one sequential prefetch. When a request is taken, the block raises a one-cycle memory request in the following cycle.

A read miss and a write miss may be outstanding at the same time. Traffic of the opposite type keeps flowing while only one of them is pending. A burst read may also start one prefetch of the next sub-block, but only when that sub-block is absent and lies inside the same block. A completion from memory frees its tracker entry in the same cycle, so a new request of the same kind can be taken in that cycle.

Top module: `l2_miss_tracker`

## Requirements
- R1: At most one read miss and at most one write miss are outstanding. A further miss of a type that is already outstanding gets `req_ready` low. An accepted miss raises `mem_req_valid` in the next cycle for one cycle, with `mem_req_kind` 0 for a read miss and 1 for a write miss.
- R2: While only a read miss is outstanding, writes are accepted, including a write miss. While only a write miss is outstanding, reads are accepted, including a read miss.
- R3: While both a read miss and a write miss are outstanding and neither completes in the current cycle, `req_ready` is low for every request, hits included.
- R4: Sub-blocks are 32 bytes and a block holds four of them. The sub-block address is `req_addr >> 5` and its low two bits give the position inside the block. `mem_req_addr` carries the sub-block address of the accepted request.
- R5: An accepted burst read raises `pf_req_valid` in the next cycle with `pf_req_addr` = its sub-block address + 1, when `lk_next_hit` is low and the position of the request inside its block is not 3. A non-burst read, a next sub-block that is present, or position 3 starts no prefetch.
- R6: Only one prefetch is outstanding at a time. A trigger that arrives while one is in flight is dropped, and the request itself is still accepted.
- R7: While `pf_en` is low, no prefetch is issued.
- R8: A write that hits shared data (`lk_hit` and `lk_shared`) takes one of NSW (default 2) upgrade slots and issues `mem_req_kind` 2. It waits when no slot is free or when a pending upgrade already targets the same sub-block.
- R9: A read or write miss to the sub-block that the outstanding prefetch targets waits for the prefetch to complete.
- R10: A completion (`mem_done_valid` with `mem_done_kind` 0 read, 1 write, 2 upgrade matched by `mem_done_addr`, 3 prefetch) frees its entry in the same cycle, and a request that depends on that entry is accepted in that same cycle.
- R11: A burst read that misses, with the next sub-block absent, raises both a read miss request and a prefetch request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_en | input | 1 | Prefetch enable |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 write, 0 read |
| req_burst | input | 1 | Request is a burst |
| req_addr | input | AW | Byte address |
| lk_hit | input | 1 | Tag lookup hit for the request |
| lk_shared | input | 1 | Hit data is held shared |
| lk_next_hit | input | 1 | Next sequential sub-block is present |
| req_ready | output | 1 | Request accepted this cycle |
| mem_req_valid | output | 1 | Miss or upgrade request to memory |
| mem_req_kind | output | 2 | 0 read miss, 1 write miss, 2 upgrade |
| mem_req_addr | output | AW-5 | Sub-block address of the memory request |
| pf_req_valid | output | 1 | Prefetch request to memory |
| pf_req_addr | output | AW-5 | Sub-block address to prefetch |
| mem_done_valid | input | 1 | Memory completion |
| mem_done_kind | input | 2 | 0 read, 1 write, 2 upgrade, 3 prefetch |
| mem_done_addr | input | AW-5 | Sub-block address of a completing upgrade |

## Verification
Two functions share a cycle in two ways. A burst read that misses with its neighbour absent launches a miss and a prefetch together. A completion arriving in the same cycle as a request that was blocked on that entry lets the request through. The bench provokes the first by pairing a missing burst read with a low next-hit flag, and checks that both request outputs rise in the next cycle with addresses one apart. It provokes the second by driving a completion alongside a stalled read miss, write miss, upgrade or prefetch-target miss, and checks that `req_ready` is high in that cycle and the new memory request follows.

// File: rtl/l2_miss_tracker.sv
module l2_miss_tracker #(
  parameter int AW         = 16,
  parameter int SB_BYTES   = 32,
  parameter int SB_PER_BLK = 4,
  parameter int NSW        = 2,
  localparam int OFFW      = $clog2(SB_BYTES),
  localparam int SBW       = AW - OFFW
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pf_en,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic           req_burst,
  input  logic [AW-1:0]  req_addr,
  input  logic           lk_hit,
  input  logic           lk_shared,
  input  logic           lk_next_hit,
  output logic           req_ready,
  output logic           mem_req_valid,
  output logic [1:0]     mem_req_kind,
  output logic [SBW-1:0] mem_req_addr,
  output logic           pf_req_valid,
  output logic [SBW-1:0] pf_req_addr,
  input  logic           mem_done_valid,
  input  logic [1:0]     mem_done_kind,
  input  logic [SBW-1:0] mem_done_addr
);
  localparam int SIW = $clog2(SB_PER_BLK);
  localparam int SWI = (NSW > 1) ? $clog2(NSW) : 1;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_UP = 2'd2, K_PF = 2'd3;

  logic [SBW-1:0] sb;
  logic           last_sb;
  assign sb      = req_addr[AW-1:OFFW];
  assign last_sb = &sb[SIW-1:0];

  logic           rd_busy, wr_busy, pf_busy;
  logic [SBW-1:0] pf_addr;
  logic [NSW-1:0] sw_busy;
  logic [SBW-1:0] sw_addr [NSW];

  logic d_rd, d_wr, d_pf;
  logic [NSW-1:0] d_sw;
  assign d_rd = mem_done_valid && mem_done_kind == K_RD;
  assign d_wr = mem_done_valid && mem_done_kind == K_WR;
  assign d_pf = mem_done_valid && mem_done_kind == K_PF;

  logic rd_free, wr_free, full, pf_hit;
  assign rd_free = !rd_busy || d_rd;
  assign wr_free = !wr_busy || d_wr;
  assign full    = !rd_free && !wr_free;
  assign pf_hit  = pf_busy && !d_pf && pf_addr == sb;

  logic rd_miss, wr_miss, sw_hit;
  assign rd_miss = !req_write && !lk_hit;
  assign wr_miss =  req_write && !lk_hit;
  assign sw_hit  =  req_write && lk_hit && lk_shared;

  logic           sw_match, sw_any;
  logic [SWI-1:0] sw_pick;
  always_comb begin
    sw_match = 1'b0;
    sw_any   = 1'b0;
    sw_pick  = '0;
    for (int i = 0; i < NSW; i++) begin
      d_sw[i] = mem_done_valid && mem_done_kind == K_UP && sw_busy[i] && sw_addr[i] == mem_done_addr;
      if (sw_busy[i] && !d_sw[i] && sw_addr[i] == sb) sw_match = 1'b1;
      if ((!sw_busy[i] || d_sw[i]) && !sw_any) begin
        sw_any  = 1'b1;
        sw_pick = SWI'(i);
      end
    end
  end

  always_comb begin
    if (full)         req_ready = 1'b0;
    else if (rd_miss) req_ready = rd_free && !pf_hit;
    else if (wr_miss) req_ready = wr_free && !pf_hit;
    else if (sw_hit)  req_ready = sw_any && !sw_match;
    else              req_ready = 1'b1;
  end

  logic acc, pf_go;
  assign acc   = req_valid && req_ready;
  assign pf_go = acc && !req_write && req_burst && pf_en && !lk_next_hit && !last_sb && (!pf_busy || d_pf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy       <= 1'b0;
      wr_busy       <= 1'b0;
      pf_busy       <= 1'b0;
      pf_addr       <= '0;
      sw_busy       <= '0;
      for (int i = 0; i < NSW; i++) sw_addr[i] <= '0;
      mem_req_valid <= 1'b0;
      mem_req_kind  <= K_RD;
      mem_req_addr  <= '0;
      pf_req_valid  <= 1'b0;
      pf_req_addr   <= '0;
    end else begin
      rd_busy <= (rd_busy && !d_rd) || (acc && rd_miss);
      wr_busy <= (wr_busy && !d_wr) || (acc && wr_miss);
      pf_busy <= (pf_busy && !d_pf) || pf_go;
      if (pf_go) pf_addr <= sb + 1'b1;
      for (int i = 0; i < NSW; i++) begin
        if (d_sw[i]) sw_busy[i] <= 1'b0;
        if (acc && sw_hit && sw_pick == SWI'(i)) begin
          sw_busy[i] <= 1'b1;
          sw_addr[i] <= sb;
        end
      end
      mem_req_valid <= acc && (rd_miss || wr_miss || sw_hit);
      mem_req_kind  <= rd_miss ? K_RD : (wr_miss ? K_WR : K_UP);
      mem_req_addr  <= sb;
      pf_req_valid  <= pf_go;
      pf_req_addr   <= sb + 1'b1;
    end
  end

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !d_rd && req_valid && rd_miss) |-> !req_ready); // R1
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && !d_wr && req_valid && wr_miss) |-> !req_ready); // R1
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && wr_busy && !d_rd && !d_wr) |-> !req_ready); // R3
  AST_MISS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (rd_miss || wr_miss)) |=> (mem_req_valid && mem_req_addr == $past(req_addr[AW-1:OFFW]))); // R4
  AST_PF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_valid |-> (pf_req_addr[SIW-1:0] != '0)); // R5
  AST_PF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pf_busy) && !$past(d_pf)) |-> !pf_req_valid); // R6
  AST_PF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_valid |-> $past(pf_en)); // R7
  AST_PF_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lk_hit && pf_hit) |-> !req_ready); // R9

  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NSW; i++)
        for (int j = i + 1; j < NSW; j++)
          AST_SW_DISTINCT: assert (!(sw_busy[i] && sw_busy[j] && sw_addr[i] == sw_addr[j])); // R8
    end
  end
endmodule

// File: tb/l2_miss_tracker_tb.sv
module l2_miss_tracker_tb;
  localparam int AW = 16;
  localparam int SBW = AW - 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pf_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic lk_hit = 1'b1, lk_shared = 1'b0, lk_next_hit = 1'b1;
  logic req_ready, mem_req_valid, pf_req_valid;
  logic [1:0] mem_req_kind;
  logic [SBW-1:0] mem_req_addr, pf_req_addr;
  logic mem_done_valid = 1'b0;
  logic [1:0] mem_done_kind = '0;
  logic [SBW-1:0] mem_done_addr = '0;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  l2_miss_tracker #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pf_en(pf_en),
    .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .lk_hit(lk_hit), .lk_shared(lk_shared), .lk_next_hit(lk_next_hit),
    .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_kind(mem_req_kind), .mem_req_addr(mem_req_addr),
    .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr),
    .mem_done_valid(mem_done_valid), .mem_done_kind(mem_done_kind), .mem_done_addr(mem_done_addr));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_done(int kind, int sbaddr);
    mem_done_valid = 1'b1;
    mem_done_kind  = 2'(kind);
    mem_done_addr  = SBW'(sbaddr);
  endtask

  task automatic idle_done(int kind, int sbaddr);
    set_done(kind, sbaddr);
    @(negedge clk);
    mem_done_valid = 1'b0;
  endtask

  // one request cycle: inputs at negedge, ready checked before the edge, outputs one negedge later
  task automatic req(string tag, bit w, bit b, int addr, bit hit, bit sh, bit nh,
                     bit exp_rdy, bit exp_mv, int exp_kind, bit exp_pv);
    req_valid = 1'b1; req_write = w; req_burst = b; req_addr = AW'(addr);
    lk_hit = hit; lk_shared = sh; lk_next_hit = nh;
    #1;
    check({tag, " ready"}, int'(req_ready), int'(exp_rdy));
    @(negedge clk);
    check({tag, " mem_req_valid"}, int'(mem_req_valid), int'(exp_mv));
    if (exp_mv) begin
      check({tag, " mem_req_kind"}, int'(mem_req_kind), exp_kind);
      check({tag, " mem_req_addr"}, int'(mem_req_addr), addr >> 5);
    end
    check({tag, " pf_req_valid"}, int'(pf_req_valid), int'(exp_pv));
    if (exp_pv) check({tag, " pf_req_addr"}, int'(pf_req_addr), (addr >> 5) + 1);
    req_valid = 1'b0; mem_done_valid = 1'b0;
    lk_hit = 1'b1; lk_shared = 1'b0; lk_next_hit = 1'b1; req_burst = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("reset mem_req_valid", int'(mem_req_valid), 0);
    check("reset pf_req_valid", int'(pf_req_valid), 0);
    check("reset ready", int'(req_ready), 1);
    @(negedge clk);

    // R1 R2 R3 R4 R10
    req("R1 read miss",         0, 0, 'h0100, 0, 0, 1, 1, 1, 0, 0);
    req("R1 second read miss",  0, 0, 'h0200, 0, 0, 1, 0, 0, 0, 0);
    req("R2 read hit",          0, 0, 'h0300, 1, 0, 1, 1, 0, 0, 0);
    req("R2 write miss",        1, 0, 'h0404, 0, 0, 1, 1, 1, 1, 0);
    req("R3 read hit blocked",  0, 0, 'h0300, 1, 0, 1, 0, 0, 0, 0);
    req("R3 write hit blocked", 1, 0, 'h0320, 1, 0, 1, 0, 0, 0, 0);
    set_done(1, 'h0404 >> 5);
    req("R10 write miss on done", 1, 0, 'h0500, 0, 0, 1, 1, 1, 1, 0);
    set_done(0, 'h0100 >> 5);
    req("R10 read miss on done",  0, 0, 'h0600, 0, 0, 1, 1, 1, 0, 0);
    idle_done(0, 0);
    idle_done(1, 0);

    // R2 reverse order
    req("R2 write miss first",  1, 0, 'h0700, 0, 0, 1, 1, 1, 1, 0);
    req("R2 read miss behind",  0, 0, 'h0800, 0, 0, 1, 1, 1, 0, 0);
    req("R3 write miss blocked",1, 0, 'h0900, 0, 0, 1, 0, 0, 0, 0);
    idle_done(0, 0);
    idle_done(1, 0);

    // R5 R7 sweep over enable, position in block and neighbour presence
    for (int en = 0; en < 2; en++)
      for (int idx = 0; idx < 4; idx++)
        for (int nh = 0; nh < 2; nh++) begin
          bit exp_pv;
          int a;
          a = 'h1000 + idx * 32;
          exp_pv = (en == 1) && (nh == 0) && (idx != 3);
          pf_en = 1'(en);
          req(en == 0 ? "R7 prefetch disabled" : "R5 prefetch trigger",
              0, 1, a, 1, 0, 1'(nh), 1, 0, 0, exp_pv);
          if (exp_pv) idle_done(3, 0);
        end
    pf_en = 1'b1;
    req("R5 non-burst no prefetch", 0, 0, 'h1040, 1, 0, 0, 1, 0, 0, 0);

    // R11 miss and prefetch together, R6 single prefetch, R9 wait on prefetch target
    req("R11 burst read miss",   0, 1, 'h2000, 0, 0, 0, 1, 1, 0, 1);
    req("R6 second trigger dropped", 0, 1, 'h3000, 1, 0, 0, 1, 0, 0, 0);
    idle_done(0, 0);
    req("R9 read miss on pf target",  0, 0, 'h2020, 0, 0, 1, 0, 0, 0, 0);
    req("R9 write miss on pf target", 1, 0, 'h2024, 0, 0, 1, 0, 0, 0, 0);
    set_done(3, 0);
    req("R9 read miss as pf completes", 0, 0, 'h2020, 0, 0, 1, 1, 1, 0, 0);
    idle_done(0, 0);

    // R8 shared write upgrades
    req("R8 upgrade A",          1, 0, 'h4000, 1, 1, 1, 1, 1, 2, 0);
    req("R8 same sub-block",     1, 0, 'h4004, 1, 1, 1, 0, 0, 0, 0);
    req("R8 upgrade B",          1, 0, 'h4020, 1, 1, 1, 1, 1, 2, 0);
    req("R8 slots full",         1, 0, 'h4040, 1, 1, 1, 0, 0, 0, 0);
    set_done(2, 'h4000 >> 5);
    req("R8 slot freed on done", 1, 0, 'h4040, 1, 1, 1, 1, 1, 2, 0);
    req("R8 B still pending",    1, 0, 'h4020, 1, 1, 1, 0, 0, 0, 0);
    req("R8 plain write hit",    1, 0, 'h4060, 1, 0, 1, 1, 0, 0, 0);

    summary();
  end
endmodule